// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block deserialises stereo audio arriving on three serial data lanes into six parallel 24-bit signed channel words. All lanes share one bit clock and one frame clock, and each lane carries one left/right pair. The framing can be set to I2S, left-justified, right-justified or a DSP-style pulse frame. The word length can be 16, 20 or 24 bits. Samples are two's complement, and narrower words are sign-extended to 24 bits.

The serial pins are sampled in the block's own clock domain. A rising bit-clock edge is seen when the sampled bit clock goes from 0 to 1 between two consecutive `clk` edges, so each bit-clock level must last at least two `clk` cycles. The frame clock and data must be stable around that rising edge. A finished frame is offered on a valid/ready output stream that carries all six channels at once. While the output holds an unaccepted frame, that frame and its valid stay unchanged until `out_ready` is seen high. Any frame that completes during that time is discarded. In replicate mode the first lane's pair drives all three output pairs, which allows the fastest sample rates to be fed through lane 0 alone. Configuration pins are expected to change only while `rst_n` is low.

Top module: `asp_rx`

## Requirements
- R1: All lanes are sampled on the same rising bit-clock edges and decoded against the one shared frame clock. Each lane's words appear only in its own output pair.
- R2: `cfg_wlen` selects the word length W: 0 gives 16 bits, 1 gives 20 bits, 2 or 3 give 24 bits. Each output word is the received W-bit value sign-extended to 24 bits.
- R3: Left-justified (`cfg_fmt`=1): the MSB is on the first rising edge at which the frame clock shows the new half's level. The following W-1 bits complete the word, and later bits in the half are ignored.
- R4: I2S (`cfg_fmt`=0): the MSB comes one bit clock later than in R3, on the second rising edge of the half. Bits after the word are ignored.
- R5: Right-justified (`cfg_fmt`=2): the word is the last W bits before the frame clock changes level, with the LSB last. Earlier bits in the half are ignored.
- R6: DSP (`cfg_fmt`=3): the frame clock is high on exactly one rising edge. The left MSB follows on the next edge, and the right word follows directly after the left LSB. The frame clock is low otherwise, and bits after the right LSB are ignored.
- R7: In formats 0 to 2, `cfg_left_high`=1 makes the frame-clock-high half the left channel. `cfg_left_high`=0 makes the low half the left channel.
- R8: Output channel k occupies `out_data[24k+23:24k]`; channel 2p is lane p left and channel 2p+1 is lane p right. In formats 0 to 2 a frame is issued when the frame clock returns to the left level. The first frame after reset is dropped because its left half has no start boundary. In DSP mode a frame is issued after its last right bit.
- R9: With `cfg_repl`=1, output pairs 1 and 2 carry lane 0's left and right words, and the data on lanes 1 and 2 is ignored.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged, and a frame completing meanwhile is discarded. An accepted frame with no new one behind it lowers `out_valid`.
- R11: After reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Shared frame clock / DSP frame pulse |
| sdata | input | NUM_LANES | Serial data, one lane per stereo pair |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_wlen | input | 2 | Word length code |
| cfg_left_high | input | 1 | Frame-clock level of the left half |
| cfg_repl | input | 1 | Copy lane 0 pair onto all pairs |
| out_valid | output | 1 | Frame available |
| out_ready | input | 1 | Consumer accepts frame |
| out_data | output | 2*NUM_LANES*24 | Six packed channel words |

## Verification
The bench fills the unused bits of every half with random noise. A decoder that takes the wrong window, for example shifted by the I2S one-bit delay or aligned to the wrong end in right-justified mode, returns corrupted words. Extreme positive and negative values at each width show whether sign extension happens at the right bit. Lanes 1 and 2 carry different data from lane 0 under replicate, so a leaking lane is visible. A directed case holds `out_ready` low across several frames: a design that overwrote the held frame or kept a dropped frame would show the wrong data or an extra handshake.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int ASP_SW = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } asp_fmt_e;

  function automatic int unsigned word_len(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [ASP_SW-1:0] sext(input logic [ASP_SW-1:0] v, input logic [1:0] code);
    case (code)
      2'd0:    return {{8{v[15]}}, v[15:0]};
      2'd1:    return {{4{v[19]}}, v[19:0]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/asp_ctl.sv
module asp_ctl
  import asp_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       lrclk,
  input  logic [1:0] cfg_fmt,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_left_high,
  output logic       shift_en,
  output logic       cap_l,
  output logic       cap_r,
  output logic       cap_nxt,
  output logic       frame_stb
);
  asp_fmt_e         fmt;
  logic             bclk_q, rise;
  logic             lr_q, started, have_bound, left_ok, dsp_act;
  logic [CNT_W-1:0] cnt, cnt_inc, cnt_n, wl, wl2;
  logic             is_dsp, chg, now_left, dsp_act_n;
  logic             shift_i, cap_l_i, cap_r_i;

  always_comb begin
    fmt       = asp_fmt_e'(cfg_fmt);
    is_dsp    = (fmt == FMT_DSP);
    wl        = CNT_W'(word_len(cfg_wlen));
    wl2       = {wl[CNT_W-2:0], 1'b0};
    rise      = bclk & ~bclk_q;
    chg       = started && (lrclk != lr_q);
    now_left  = (lrclk == cfg_left_high);
    cnt_inc   = (cnt == '1) ? cnt : cnt + 1'b1;
    dsp_act_n = lrclk | dsp_act;
    if (is_dsp) cnt_n = lrclk ? '0 : cnt_inc;
    else        cnt_n = chg ? '0 : cnt_inc;
    case (fmt)
      FMT_RJ:  shift_i = 1'b1;
      FMT_LJ:  shift_i = (cnt_n < wl);
      FMT_I2S: shift_i = (cnt_n >= 1) && (cnt_n <= wl);
      default: shift_i = dsp_act_n && (cnt_n >= 1) && (cnt_n <= wl2);
    endcase
    if (is_dsp) begin
      cap_l_i = dsp_act_n && (cnt_n == wl);
      cap_r_i = dsp_act_n && (cnt_n == wl2);
    end else begin
      cap_l_i = chg && !now_left && have_bound;
      cap_r_i = chg && now_left && left_ok;
    end
    shift_en = rise && shift_i;
    cap_l    = rise && cap_l_i;
    cap_r    = rise && cap_r_i;
    cap_nxt  = is_dsp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      lr_q       <= 1'b0;
      started    <= 1'b0;
      have_bound <= 1'b0;
      left_ok    <= 1'b0;
      dsp_act    <= 1'b0;
      cnt        <= '1;
      frame_stb  <= 1'b0;
    end else begin
      bclk_q    <= bclk;
      frame_stb <= cap_r;
      if (rise) begin
        started <= 1'b1;
        lr_q    <= lrclk;
        cnt     <= cnt_n;
        if (!is_dsp && chg) have_bound <= 1'b1;
        if (cap_l_i)      left_ok <= 1'b1;
        else if (cap_r_i) left_ok <= 1'b0;
        if (is_dsp) dsp_act <= cap_r_i ? 1'b0 : dsp_act_n;
      end
    end
  end

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb); // R8
endmodule

// File: rtl/asp_lane.sv
module asp_lane
  import asp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd,
  input  logic              shift_en,
  input  logic              cap_l,
  input  logic              cap_r,
  input  logic              cap_nxt,
  input  logic [1:0]        cfg_wlen,
  output logic [ASP_SW-1:0] left_w,
  output logic [ASP_SW-1:0] right_w
);
  logic [ASP_SW-1:0] sr, sr_n, src;

  always_comb begin
    sr_n = {sr[ASP_SW-2:0], sd};
    src  = cap_nxt ? sr_n : sr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      left_w  <= '0;
      right_w <= '0;
    end else begin
      if (shift_en) sr <= sr_n;
      if (cap_l) left_w  <= sext(src, cfg_wlen);
      if (cap_r) right_w <= sext(src, cfg_wlen);
    end
  end

  AST_SEXT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wlen == 2'd0) |-> (left_w[ASP_SW-1:15] == '0 || left_w[ASP_SW-1:15] == '1)); // R2
endmodule

// File: rtl/asp_out.sv
module asp_out
  import asp_pkg::*;
#(
  parameter int NL = 3,
  localparam int DW = 2 * NL * ASP_SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic [DW-1:0] lane_w,
  input  logic          cfg_repl,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] nxt_data;
  logic          ld;

  for (genvar k = 0; k < 2 * NL; k++) begin : g_ch
    localparam int SIDE = k % 2;
    assign nxt_data[k*ASP_SW +: ASP_SW] =
      cfg_repl ? lane_w[SIDE*ASP_SW +: ASP_SW] : lane_w[k*ASP_SW +: ASP_SW];
    if (k >= 2) begin : g_chk
      AST_REPL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && cfg_repl) |=> (out_data[k*ASP_SW +: ASP_SW] == out_data[SIDE*ASP_SW +: ASP_SW])); // R9
    end
  end

  assign ld = frame_stb && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_stb) |=> !out_valid); // R10
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int NUM_LANES = 3,
  parameter int CNT_W     = 7,
  localparam int DW       = 2 * NUM_LANES * ASP_SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk,
  input  logic                 lrclk,
  input  logic [NUM_LANES-1:0] sdata,
  input  logic [1:0]           cfg_fmt,
  input  logic [1:0]           cfg_wlen,
  input  logic                 cfg_left_high,
  input  logic                 cfg_repl,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_data
);
  logic          shift_en, cap_l, cap_r, cap_nxt, frame_stb;
  logic [DW-1:0] lane_w;

  asp_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_left_high(cfg_left_high),
    .shift_en(shift_en), .cap_l(cap_l), .cap_r(cap_r), .cap_nxt(cap_nxt),
    .frame_stb(frame_stb)
  );

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
    asp_lane u_lane (
      .clk(clk), .rst_n(rst_n), .sd(sdata[p]),
      .shift_en(shift_en), .cap_l(cap_l), .cap_r(cap_r), .cap_nxt(cap_nxt),
      .cfg_wlen(cfg_wlen),
      .left_w(lane_w[(2*p)*ASP_SW +: ASP_SW]),
      .right_w(lane_w[(2*p+1)*ASP_SW +: ASP_SW])
    );
  end

  asp_out #(.NL(NUM_LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .lane_w(lane_w),
    .cfg_repl(cfg_repl), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/sim_asp_rx.sv
module sim_asp_rx;
  localparam int CLK_P = 10;
  localparam int DW = 144;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bclk = 1'b0;
  logic          lrclk = 1'b0;
  logic [2:0]    sdata = 3'b000;
  logic [1:0]    cfg_fmt = 2'd0;
  logic [1:0]    cfg_wlen = 2'd2;
  logic          cfg_left_high = 1'b0;
  logic          cfg_repl = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int nchk = 0;
  int nerr = 0;
  int rdy_mode = 0;
  logic rdy_force = 1'b1;
  logic [DW-1:0] expq[$];
  logic [DW-1:0] gotq[$];

  asp_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_left_high(cfg_left_high),
    .cfg_repl(cfg_repl), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #(CLK_P/2) clk = ~clk;

  // ready driver and output monitor in one block: the handshake seen at the next edge
  always @(negedge clk) begin
    logic r;
    case (rdy_mode)
      0:       r = 1'b1;
      1:       r = (($urandom % 4) != 0);
      default: r = rdy_force;
    endcase
    out_ready = r;
    if (rst_n && out_valid && r) gotq.push_back(out_data);
  end

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int w);
    if (w == 16) return {{8{v[15]}}, v[15:0]};
    if (w == 20) return {{4{v[19]}}, v[19:0]};
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_of(input logic [2:0][23:0] L, input logic [2:0][23:0] R,
                                           input int w, input logic repl);
    logic [DW-1:0] e;
    for (int k = 0; k < 6; k++) begin
      int ln = repl ? 0 : k / 2;
      e[k*24 +: 24] = sx((k % 2) ? R[ln] : L[ln], w);
    end
    return e;
  endfunction

  function automatic logic tbit(input int fmt, input int w, input logic [23:0] v, input int i, input logic nz);
    case (fmt)
      1:       return (i < w) ? v[w-1-i] : nz;             // R3 window
      0:       return (i >= 1 && i <= w) ? v[w-i] : nz;    // R4 window
      default: return (i >= 32 - w) ? v[31-i] : nz;        // R5 window
    endcase
  endfunction

  task automatic bit_tx(input logic lr, input logic [2:0] d);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_tx(input int fmt, input int w, input logic lh,
                          input logic [2:0][23:0] L, input logic [2:0][23:0] R);
    logic [2:0] d;
    if (fmt == 3) begin
      for (int i = 0; i < 64; i++) begin
        for (int l = 0; l < 3; l++) begin
          if (i >= 1 && i <= w)          d[l] = L[l][w-i];
          else if (i > w && i <= 2 * w)  d[l] = R[l][2*w-i];
          else                           d[l] = 1'($urandom);
        end
        bit_tx(i == 0, d);
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < 32; i++) begin
          for (int l = 0; l < 3; l++)
            d[l] = tbit(fmt, w, h ? R[l] : L[l], i, 1'($urandom));
          bit_tx(h ? ~lh : lh, d);
        end
      end
    end
  endtask

  task automatic do_reset(input int fmt, input logic [1:0] wc, input logic lh, input logic repl);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fmt = 2'(fmt); cfg_wlen = wc; cfg_left_high = lh; cfg_repl = repl;
    bclk = 1'b0; lrclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expq.delete(); gotq.delete();
    chk(out_valid == 1'b0, "R11 reset valid", DW'(out_valid), '0);
  endtask

  function automatic logic [23:0] pick(input int idx, input int w);
    logic [23:0] m = (24'h1 << w) - 1;
    if (idx == 1) return m >> 1;                 // most positive
    if (idx == 2) return 24'h1 << (w - 1);       // most negative
    return 24'($urandom) & m;
  endfunction

  task automatic run_cfg(input int fmt, input logic [1:0] wc, input logic lh,
                         input logic repl, input int n, input string tag);
    int w = wbits(wc);
    logic [2:0][23:0] L, R;
    do_reset(fmt, wc, lh, repl);
    for (int idx = 0; idx <= n; idx++) begin
      for (int l = 0; l < 3; l++) begin
        L[l] = pick(idx, w);
        R[l] = pick((idx == 1) ? 2 : (idx == 2) ? 1 : idx, w);
      end
      frame_tx(fmt, w, lh, L, R);
      // R8: first frame after reset and the unterminated last one are not issued in L/R formats
      if (fmt == 3 || (idx != 0 && idx != n)) expq.push_back(exp_of(L, R, w, repl));
    end
    repeat (40) @(negedge clk);
    chk(gotq.size() == expq.size(), {tag, " R8 frame count"}, DW'(gotq.size()), DW'(expq.size()));
    for (int i = 0; i < expq.size() && i < gotq.size(); i++)
      chk(gotq[i] == expq[i], tag, gotq[i], expq[i]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1839));
    // R1 R2 R3 R4 R5 R6 R7 across all formats, widths and polarities
    for (int f = 0; f < 4; f++)
      for (int wc = 0; wc < 4; wc++) begin
        string t;
        case (f)
          0: t = "R4 I2S R1 R2 R7";
          1: t = "R3 LJ R1 R2 R7";
          2: t = "R5 RJ R1 R2 R7";
          default: t = "R6 DSP R1 R2";
        endcase
        rdy_mode = (wc % 2);
        run_cfg(f, 2'(wc), 1'((f + wc) % 2), 1'b0, 4, t);
      end
    // R9 replicate
    rdy_mode = 0;
    run_cfg(1, 2'd2, 1'b1, 1'b1, 4, "R9 replicate LJ");
    run_cfg(3, 2'd0, 1'b0, 1'b1, 3, "R9 replicate DSP");
    // R10 back-pressure: hold ready low across several frames
    begin
      logic [2:0][23:0] L, R;
      logic [DW-1:0] first;
      logic [DW-1:0] keep;
      rdy_mode = 2; rdy_force = 1'b0;
      do_reset(1, 2'd2, 1'b1, 1'b0);
      for (int idx = 0; idx < 4; idx++) begin
        for (int l = 0; l < 3; l++) begin
          L[l] = 24'($urandom); R[l] = 24'($urandom);
        end
        if (idx == 1) first = exp_of(L, R, 24, 1'b0);
        frame_tx(1, 24, 1'b1, L, R);
      end
      repeat (10) @(negedge clk);
      keep = out_data;
      chk(out_valid == 1'b1, "R10 held valid", DW'(out_valid), DW'(1));
      chk(keep == first, "R10 held frame kept", keep, first);
      rdy_force = 1'b1;
      @(negedge clk);
      rdy_force = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 newer frame dropped", DW'(out_valid), '0);
      chk(gotq.size() == 1, "R10 single handshake", DW'(gotq.size()), DW'(1));
      rdy_mode = 0;
    end
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule